// File: doc/BRIEF.md
# Oversampled Edge Coincidence Counter

This block watches two free-running periodic signals that have no fixed phase relation, a main input and an auxiliary input, using a sample clock that is much faster than either. Neither observed signal clocks any flip-flop. Both are treated as asynchronous data. Each passes through a synchroniser, and its rising edges are found by comparing one sample with the next. When both inputs show a rising edge in the same sample period, the block emits a registered one-cycle coincidence pulse.

A start pulse arms a capture counter. From then on it counts rising edges of the main input. At the first coincidence it freezes its value and raises a done flag. The frozen count gives a coarse vernier reading: the number of main periods that pass before the phases of the two inputs line up. The count and the flag stay put until the next start.

The sample clock must run at least twice as fast as the faster observed input, and preferably several times faster. Otherwise edges are lost.

Top module: `vernier_edge_coinc`

## Requirements
- R1: While `rst_n` is low at a rising edge of `clk`, the synchroniser and edge history, `coinc_pulse`, `edge_count` and `done` are cleared. All outputs read zero from the cycle after that edge.
- R2: A rising edge on an input is a sample of 1 whose previous sample was 0. Falling edges and steady levels produce no edge.
- R3: An input change captured at sample edge k raises `coinc_pulse`, if both inputs rose together, from edge k+2 until edge k+3. The pulse is exactly one cycle wide.
- R4: Rising edges of the two inputs that land in different sample periods give no coincidence. This holds even when they are one period apart. The same holds when the inputs merely share a high level.
- R5: When `start` is sampled high, `edge_count` reads 0 and `done` reads 0 from the next cycle, and the counter is armed.
- R6: While armed, each main rising edge without a simultaneous auxiliary rising edge adds exactly one to `edge_count`. The change appears with the same latency as R3.
- R7: The first coincidence while armed sets `done` in the same cycle as `coinc_pulse`. The count keeps its previous value, so the coinciding main edge is not counted.
- R8: After `done` rises, `edge_count` and `done` stay unchanged until the next `start`. Later coincidences still pulse `coinc_pulse` but do not alter them.
- R9: `edge_count` saturates at 2^CNT_W-1 (65535 by default) and does not wrap.
- R10: After reset and before any `start`, main edges and coincidences leave `edge_count` at 0 and `done` at 0. `coinc_pulse` still reports coincidences in this state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast sample clock; the only clock of the block |
| rst_n | input | 1 | Synchronous active-low reset |
| main_in | input | 1 | Observed main periodic signal, asynchronous |
| aux_in | input | 1 | Observed second periodic signal, asynchronous |
| start | input | 1 | Clears and arms the capture counter |
| coinc_pulse | output | 1 | One-cycle pulse on simultaneous rising edges |
| edge_count | output | CNT_W (16) | Main rising edges counted since start, frozen at coincidence |
| done | output | 1 | High once a coincidence has frozen the count |

## Verification
The checker watches several rules on every cycle. It checks that the coincidence pulse never lasts two cycles and that a start clears the count and flag. It checks that the count moves by at most one per cycle and that a saturated count stays saturated. It also checks that done and the count are frozen while done is high, and that done only rises together with a coincidence pulse. Other behaviour depends on where edges fall in time, and only the bench scenarios can show it. This covers the exact three-cycle latency and the rejection of edges one period apart or of shared high levels. It also covers excluding the coinciding edge from the count, staying idle before the first start, and reaching saturation after 65536 main edges.

// File: rtl/vec_pkg.sv
// Package: shared types and defaults for the edge coincidence counter.
package vec_pkg;

    // Default sizing
    localparam int DEF_CNT_W   = 16;
    localparam int DEF_STAGES  = 2;
    localparam int NUM_CH      = 2;
    localparam int CH_MAIN     = 0;
    localparam int CH_AUX      = 1;

    // Capture counter states
    typedef enum logic [1:0] {
        CAP_IDLE  = 2'd0,
        CAP_ARMED = 2'd1,
        CAP_HELD  = 2'd2
    } cap_state_e;

endpackage

// File: rtl/vec_edge_sampler.sv
// Module: vec_edge_sampler
// Synchronises one asynchronous input into the sample clock domain through
// STAGES flip-flops. It flags a rising edge when the synchronised value is 1
// and the next older sample is 0.
// Assumes the sample clock is at least twice the input's toggle rate.
module vec_edge_sampler #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise
);

    localparam int LAST = STAGES - 1;

    logic [LAST:0] sync_q;
    logic          prev_q;

    // Shift the raw input through the synchroniser chain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
        end else begin
            sync_q[0] <= din;
            for (int i = 1; i <= LAST; i++) begin
                sync_q[i] <= sync_q[i-1];
            end
        end
    end

    // Keep one further delayed copy for edge comparison
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
        end else begin
            prev_q <= sync_q[LAST];
        end
    end

    assign rise = sync_q[LAST] & ~prev_q;

endmodule

// File: rtl/vec_coinc_reg.sv
// Module: vec_coinc_reg
// ANDs the per-channel rising-edge flags of one sample period and registers
// the result as a single-cycle pulse. The unregistered AND is also offered
// so that the capture counter acts on the same cycle's decision.
// Assumes both flags come from the same sample clock domain.
module vec_coinc_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic rise_main,
    input  logic rise_aux,
    output logic hit_now,
    output logic pulse
);

    assign hit_now = rise_main & rise_aux;

    // Register the coincidence decision
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pulse <= 1'b0;
        end else begin
            pulse <= hit_now;
        end
    end

endmodule

// File: rtl/vec_capture_counter.sv
// Module: vec_capture_counter
// Counts main-input rising edges after a start, saturating at the maximum.
// It freezes the count and raises done on the first coincidence.
// Start has priority over any edge in the same cycle. The counter idles
// until the first start after reset.
module vec_capture_counter
    import vec_pkg::*;
#(
    parameter int CNT_W = DEF_CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             rise_main,
    input  logic             hit_now,
    output logic [CNT_W-1:0] count,
    output logic             done
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    cap_state_e state_q;

    // Sequence idle / armed / held
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CAP_IDLE;
        end else if (start) begin
            state_q <= CAP_ARMED;
        end else if (state_q == CAP_ARMED && hit_now) begin
            state_q <= CAP_HELD;
        end
    end

    // Clear on start, count main edges while armed, saturate at maximum
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (start) begin
            count <= '0;
        end else if (state_q == CAP_ARMED && rise_main && !hit_now
                     && count != CNT_MAX) begin
            count <= count + 1'b1;
        end
    end

    assign done = (state_q == CAP_HELD);

endmodule

// File: rtl/vernier_edge_coinc.sv
// Module: vernier_edge_coinc (top)
// Oversamples two asynchronous periodic inputs and detects simultaneous
// rising edges. It counts main edges from start to the first coincidence.
// Assumes clk runs at least twice as fast as the faster observed input.
module vernier_edge_coinc
    import vec_pkg::*;
#(
    parameter int CNT_W  = DEF_CNT_W,
    parameter int STAGES = DEF_STAGES
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             main_in,
    input  logic             aux_in,
    input  logic             start,
    output logic             coinc_pulse,
    output logic [CNT_W-1:0] edge_count,
    output logic             done
);

    logic [NUM_CH-1:0] raw_in;
    logic [NUM_CH-1:0] rise;
    logic              hit_now;

    assign raw_in[CH_MAIN] = main_in;
    assign raw_in[CH_AUX]  = aux_in;

    // One synchroniser and edge detector per observed input
    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        vec_edge_sampler #(
            .STAGES (STAGES)
        ) u_samp (
            .clk   (clk),
            .rst_n (rst_n),
            .din   (raw_in[ch]),
            .rise  (rise[ch])
        );
    end

    vec_coinc_reg u_coinc (
        .clk       (clk),
        .rst_n     (rst_n),
        .rise_main (rise[CH_MAIN]),
        .rise_aux  (rise[CH_AUX]),
        .hit_now   (hit_now),
        .pulse     (coinc_pulse)
    );

    vec_capture_counter #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .rise_main (rise[CH_MAIN]),
        .hit_now   (hit_now),
        .count     (edge_count),
        .done      (done)
    );

endmodule

// File: rtl/vernier_edge_coinc_chk.sv
// Module: vernier_edge_coinc_chk
// Checker bound to the top. It relates ports over time only.
module vernier_edge_coinc_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             coinc_pulse,
    input logic [CNT_W-1:0] edge_count,
    input logic             done
);

    localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        coinc_pulse |=> !coinc_pulse); // R3

    AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (edge_count == '0) && !done); // R5

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> (edge_count == $past(edge_count))
                || (edge_count == $past(edge_count) + 1'b1)); // R6

    AST_DONE_WITH_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> coinc_pulse); // R7

    AST_HELD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done && $stable(edge_count)); // R8

    AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_count == CMAX && !start) |=> edge_count == CMAX); // R9

endmodule

bind vernier_edge_coinc vernier_edge_coinc_chk #(
    .CNT_W (CNT_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .coinc_pulse (coinc_pulse),
    .edge_count  (edge_count),
    .done        (done)
);

// File: tb/vernier_edge_coinc_test.sv
module vernier_edge_coinc_test;

    localparam int CNT_W = 16;
    localparam int NV    = 39;
    localparam int LAT   = 3;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             main_in = 1'b0;
    logic             aux_in = 1'b0;
    logic             start = 1'b0;
    logic             coinc_pulse;
    logic [CNT_W-1:0] edge_count;
    logic             done;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    vernier_edge_coinc #(.CNT_W(CNT_W)) uut (
        .clk(clk), .rst_n(rst_n), .main_in(main_in), .aux_in(aux_in),
        .start(start), .coinc_pulse(coinc_pulse), .edge_count(edge_count),
        .done(done)
    );

    // Vectors {start, main, aux}, one per sample cycle
    localparam logic [2:0] VEC [NV] = '{
        3'b000, 3'b011, 3'b011, 3'b000, 3'b000, 3'b000,   // R10 idle coincidence
        3'b100, 3'b000,                                   // R5 start
        3'b010, 3'b000, 3'b010, 3'b000,                   // R6 main edges
        3'b001, 3'b000,                                   // R2 aux alone
        3'b010, 3'b011, 3'b000,                           // R4 level match
        3'b001, 3'b011, 3'b000,                           // R4 one cycle apart
        3'b010, 3'b001, 3'b011, 3'b000,                   // R2 fall then rise
        3'b011, 3'b000,                                   // R7 coincidence
        3'b011, 3'b000, 3'b010,                           // R8 ignored
        3'b000, 3'b000, 3'b000,
        3'b100, 3'b000, 3'b011,                           // R7 immediate
        3'b000, 3'b000, 3'b000, 3'b000
    };

    task automatic chk(input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Watchdog: expiry counts as a failed check
    initial begin
        repeat (199000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic rm [NV];
        logic ra [NV];
        logic m_armed;
        logic m_done;
        int   m_cnt;
        logic e_pulse;

        m_armed = 0; m_done = 0; m_cnt = 0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 count", 32'(edge_count), 0);
        chk("R1 done", 32'(done), 0);
        chk("R1 pulse", 32'(coinc_pulse), 0);

        for (int j = 0; j < NV; j++) begin
            rm[j] = VEC[j][1] & ~((j > 0) ? VEC[j-1][1] : 1'b0);
            ra[j] = VEC[j][0] & ~((j > 0) ? VEC[j-1][0] : 1'b0);
        end

        // Walk the vector table with a behavioural model
        for (int j = 0; j < NV + LAT; j++) begin
            if (j > 0 && j - 1 < NV && VEC[j-1][2]) begin
                m_armed = 1; m_done = 0; m_cnt = 0;
            end
            e_pulse = 0;
            if (j >= LAT) begin
                e_pulse = rm[j-LAT] & ra[j-LAT];
                if (m_armed) begin
                    if (e_pulse) begin
                        m_done = 1; m_armed = 0;
                    end else if (rm[j-LAT] && m_cnt < 65535) begin
                        m_cnt++;
                    end
                end
            end
            chk($sformatf("R3/R4 pulse cycle %0d", j), 32'(coinc_pulse), 32'(e_pulse));
            chk($sformatf("R6/R10 count cycle %0d", j), 32'(edge_count), m_cnt);
            chk($sformatf("R7/R8 done cycle %0d", j), 32'(done), 32'(m_done));
            if (j < NV) begin
                start   = VEC[j][2];
                main_in = VEC[j][1];
                aux_in  = VEC[j][0];
            end else begin
                start = 0; main_in = 0; aux_in = 0;
            end
            @(negedge clk);
        end
        chk("R7 final count", 32'(edge_count), 0);
        chk("R7 final done", 32'(done), 1);

        // R1 reset while held
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk("R1 count after reset", 32'(edge_count), 0);
        chk("R1 done after reset", 32'(done), 0);

        // R9 saturation: 65536 main edges, then a coincidence
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k < 65536; k++) begin
            main_in = 1'b1;
            @(negedge clk);
            main_in = 1'b0;
            @(negedge clk);
        end
        repeat (4) @(negedge clk);
        chk("R9 saturated count", 32'(edge_count), 65535);
        chk("R9 done low", 32'(done), 0);
        main_in = 1'b1; aux_in = 1'b1;
        repeat (3) @(negedge clk);
        chk("R7 pulse at saturation", 32'(coinc_pulse), 1);
        chk("R7 done at saturation", 32'(done), 1);
        chk("R7 count held", 32'(edge_count), 65535);
        @(negedge clk);
        chk("R3 pulse single", 32'(coinc_pulse), 0);
        main_in = 1'b0; aux_in = 1'b0;
        repeat (4) @(negedge clk);
        chk("R8 held done", 32'(done), 1);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule